// File: doc/BRIEF.md
# Multi-Pipe Receive Address Matcher

This block sits behind a packet receiver and decides which of six logical receive pipes an incoming packet belongs to. All pipes share one radio channel, so the only thing that separates them is the address at the head of each packet. The receiver hands the address bytes over one per cycle, first byte marked with a start strobe. The block gathers as many bytes as the programmed address width asks for. It compares the result against every enabled pipe and reports a match flag together with a 3-bit pipe code that a status word can carry directly.

Pipe 0 owns a fully independent address of up to five bytes. Pipes 1 to 5 share one common set of upper bytes and differ only in their lowest byte, which keeps the configuration small while still giving five distinct addresses. Settings are loaded through a plain write-only register port of 4-bit offset and 8-bit data. The matching rules are all at the ports: one comparison per packet, lowest pipe number first, and a reserved code for "no pipe".

Top module: `mpipe_addr_match`

## Requirements
- R1: After reset `match_valid` and `match_hit` are 0 and `match_pipe` is 3'b111.
- R2: Pipe 0 compares against its own five address bytes, written at offsets 2 to 6 (offset 2 holds byte 0, the least significant). The byte received with `rx_sof` is address byte 0, and later bytes follow in rising order.
- R3: Pipes 1 to 5 compare against one shared set of address bytes 1 to 4, written at offsets 7 to 10 (offset 7 is byte 1). Each pipe has its own byte 0, written at offset 11 + (pipe − 1).
- R4: Offset 1 sets the address width in bytes. Only the values 3, 4 and 5 are accepted, and a write of any other value leaves the width unchanged. Only the first width bytes of a packet are compared. Bytes that arrive after those, up to the next `rx_sof`, are ignored and produce no further result.
- R5: Bit p of the value written at offset 0 enables pipe p (bits 5:0). A disabled pipe never matches.
- R6: When no enabled pipe matches, `match_hit` is 0 and `match_pipe` is 3'b111. On a match `match_hit` is 1 and `match_pipe` holds the pipe number, 0 to 5.
- R7: When several enabled pipes match the same address, the lowest pipe number is reported.
- R8: When the final address byte is sampled at clock edge k, `match_valid` is high for exactly the one cycle after edge k+1. `match_hit` and `match_pipe` change at edge k+1 and then hold until the next result.
- R9: A byte with `rx_sof` set always starts a new address, and any partly gathered address is discarded.
- R10: A register write sampled at the same edge as the final address byte applies to that packet's comparison. A write sampled one edge later does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register offset |
| cfg_wdata | input | 8 | Register write data |
| rx_valid | input | 1 | Address byte valid |
| rx_sof | input | 1 | Marks the first address byte of a packet |
| rx_byte | input | 8 | Received address byte |
| match_valid | output | 1 | One-cycle pulse when a result is available |
| match_hit | output | 1 | Address matched an enabled pipe |
| match_pipe | output | 3 | Matched pipe number, 3'b111 when none |

## Verification
The case that needs care is a register write landing in the same cycle as the last address byte. The configuration update and the comparison then meet at the same edge. The bench times a pipe-enable write to coincide with the final byte, and then one cycle later. It expects the first write to decide that packet's result and the second to leave it unchanged. Alongside this, a sweep over every enable mask, each legal width and a set of aliasing addresses has the bench compute the lowest matching pipe arithmetically and compare it with the reported code.

// File: rtl/rxm_pkg.sv
package rxm_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_PIPES = 6;
    localparam int MAX_AW    = 5;
    localparam int MIN_AW    = 3;
    localparam int ADDR_W    = MAX_AW * BYTE_W;
    localparam int SHARED_W  = ADDR_W - BYTE_W;
    localparam int CODE_W    = 3;
    localparam int CNT_W     = $clog2(MAX_AW + 1);
    localparam int REG_AW    = 4;

    // register offsets
    localparam int OFS_ENABLE      = 0;
    localparam int OFS_WIDTH       = 1;
    localparam int OFS_P0_BASE     = 2;
    localparam int OFS_SHARED_BASE = OFS_P0_BASE + MAX_AW;
    localparam int OFS_LOW_BASE    = OFS_SHARED_BASE + MAX_AW - 1;

    localparam logic [CODE_W-1:0] CODE_NONE = '1;

    typedef struct packed {
        logic [NUM_PIPES-1:0]                en;
        logic [CNT_W-1:0]                    width;
        logic [ADDR_W-1:0]                   p0;
        logic [SHARED_W-1:0]                 shared;
        logic [NUM_PIPES-2:0][BYTE_W-1:0]    low;
    } match_cfg_t;

    typedef struct packed {
        logic                 done;
        logic [CNT_W-1:0]     width;
        logic [ADDR_W-1:0]    addr;
    } rx_addr_t;

    typedef struct packed {
        logic                 hit;
        logic [CODE_W-1:0]    pipe;
    } match_res_t;

    function automatic logic [ADDR_W-1:0] width_mask(input logic [CNT_W-1:0] w);
        logic [ADDR_W-1:0] m;
        m = '0;
        for (int b = 0; b < MAX_AW; b++)
            if (b < int'(w)) m[b*BYTE_W +: BYTE_W] = '1;
        return m;
    endfunction

    function automatic logic [ADDR_W-1:0] pipe_address(input match_cfg_t c, input int idx);
        if (idx == 0) return c.p0;
        return {c.shared, c.low[idx-1]};
    endfunction

    function automatic logic width_legal(input logic [BYTE_W-1:0] v);
        return (int'(v) >= MIN_AW) && (int'(v) <= MAX_AW);
    endfunction

    function automatic logic ofs_is(input logic [REG_AW-1:0] a, input int ofs);
        return int'(a) == ofs;
    endfunction

endpackage

// File: rtl/rxm_cfg_regs.sv
module rxm_cfg_regs
    import rxm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [REG_AW-1:0]    addr,
    input  logic [BYTE_W-1:0]    wdata,
    output match_cfg_t           cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.en     <= NUM_PIPES'(1);
            cfg.width  <= CNT_W'(MAX_AW);
            cfg.p0     <= {MAX_AW{8'hE7}};
            cfg.shared <= {(MAX_AW-1){8'hC2}};
            for (int p = 0; p < NUM_PIPES - 1; p++)
                cfg.low[p] <= BYTE_W'(8'hC3 + p);
        end else if (we) begin
            if (ofs_is(addr, OFS_ENABLE))
                cfg.en <= wdata[NUM_PIPES-1:0];
            if (ofs_is(addr, OFS_WIDTH) && width_legal(wdata))
                cfg.width <= wdata[CNT_W-1:0];
            for (int b = 0; b < MAX_AW; b++)
                if (ofs_is(addr, OFS_P0_BASE + b))
                    cfg.p0[b*BYTE_W +: BYTE_W] <= wdata;
            for (int b = 0; b < MAX_AW - 1; b++)
                if (ofs_is(addr, OFS_SHARED_BASE + b))
                    cfg.shared[b*BYTE_W +: BYTE_W] <= wdata;
            for (int p = 0; p < NUM_PIPES - 1; p++)
                if (ofs_is(addr, OFS_LOW_BASE + p))
                    cfg.low[p] <= wdata;
        end
    end

    // R4
    width_range_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(cfg.width) >= MIN_AW) && (int'(cfg.width) <= MAX_AW));

endmodule

// File: rtl/rxm_addr_collect.sv
module rxm_addr_collect
    import rxm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rx_valid,
    input  logic                 rx_sof,
    input  logic [BYTE_W-1:0]    rx_byte,
    input  logic [CNT_W-1:0]     cfg_width,
    output rx_addr_t             col
);

    logic [CNT_W-1:0] cnt;
    logic             busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            busy      <= 1'b0;
            col.done  <= 1'b0;
            col.width <= CNT_W'(MAX_AW);
            col.addr  <= '0;
        end else begin
            col.done <= 1'b0;
            if (rx_valid && rx_sof) begin
                col.addr  <= ADDR_W'(rx_byte);
                col.width <= cfg_width;
                cnt       <= CNT_W'(1);
                busy      <= 1'b1;
            end else if (rx_valid && busy) begin
                for (int b = 1; b < MAX_AW; b++)
                    if (int'(cnt) == b) col.addr[b*BYTE_W +: BYTE_W] <= rx_byte;
                cnt <= cnt + CNT_W'(1);
                if (cnt + CNT_W'(1) == col.width) begin
                    col.done <= 1'b1;
                    busy     <= 1'b0;
                end
            end
        end
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < col.width));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        col.done |=> !col.done);

endmodule

// File: rtl/rxm_pipe_compare.sv
module rxm_pipe_compare
    import rxm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  rx_addr_t      col,
    input  match_cfg_t    cfg,
    output logic          match_valid,
    output match_res_t    res
);

    logic [ADDR_W-1:0]    mask;
    logic [NUM_PIPES-1:0] pipe_hit;
    match_res_t           pick;

    assign mask = width_mask(col.width);

    generate
        for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
            logic [ADDR_W-1:0] ref_addr;
            assign ref_addr    = pipe_address(cfg, p);
            assign pipe_hit[p] = cfg.en[p] && (((ref_addr ^ col.addr) & mask) == '0);
        end
    endgenerate

    always_comb begin
        pick.hit  = 1'b0;
        pick.pipe = CODE_NONE;
        for (int p = NUM_PIPES - 1; p >= 0; p--) begin
            if (pipe_hit[p]) begin
                pick.hit  = 1'b1;
                pick.pipe = CODE_W'(p);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            match_valid <= 1'b0;
            res.hit     <= 1'b0;
            res.pipe    <= CODE_NONE;
        end else begin
            match_valid <= col.done;
            if (col.done) res <= pick;
        end
    end

    // R6
    none_code_chk: assert property (@(posedge clk) disable iff (rst)
        match_valid |-> (res.hit != (res.pipe == CODE_NONE)));

    // R5
    enabled_only_chk: assert property (@(posedge clk) disable iff (rst)
        (match_valid && res.hit) |-> ((($past(cfg.en) >> res.pipe) & NUM_PIPES'(1)) != '0));

    // R7
    lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (match_valid && res.hit) |->
            (($past(pipe_hit) & ((NUM_PIPES'(1) << res.pipe) - NUM_PIPES'(1))) == '0));

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        match_valid |=> !match_valid);

endmodule

// File: rtl/mpipe_addr_match.sv
module mpipe_addr_match
    import rxm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [3:0]    cfg_addr,
    input  logic [7:0]    cfg_wdata,
    input  logic          rx_valid,
    input  logic          rx_sof,
    input  logic [7:0]    rx_byte,
    output logic          match_valid,
    output logic          match_hit,
    output logic [2:0]    match_pipe
);

    match_cfg_t cfg;
    rx_addr_t   col;
    match_res_t res;

    rxm_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    rxm_addr_collect u_collect (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_sof    (rx_sof),
        .rx_byte   (rx_byte),
        .cfg_width (cfg.width),
        .col       (col)
    );

    rxm_pipe_compare u_compare (
        .clk         (clk),
        .rst         (rst),
        .col         (col),
        .cfg         (cfg),
        .match_valid (match_valid),
        .res         (res)
    );

    assign match_hit  = res.hit;
    assign match_pipe = res.pipe;

endmodule

// File: tb/tb_mpipe_addr_match.sv
module tb_mpipe_addr_match;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       rx_valid = 1'b0;
    logic       rx_sof = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       match_valid;
    logic       match_hit;
    logic [2:0] match_pipe;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 0;

    logic [39:0] m_pa [6];
    logic [5:0]  m_en;
    int          m_w;

    always #5 clk = ~clk;

    mpipe_addr_match dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_byte(rx_byte),
        .match_valid(match_valid), .match_hit(match_hit), .match_pipe(match_pipe)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // expected pipe: lowest enabled pipe whose first m_w bytes agree
    function automatic int model(input logic [39:0] a);
        logic [39:0] mask = '0;
        for (int b = 0; b < 5; b++) if (b < m_w) mask[b*8 +: 8] = 8'hFF;
        for (int p = 0; p < 6; p++)
            if (m_en[p] && (((a ^ m_pa[p]) & mask) == 40'd0)) return p;
        return 7;
    endfunction

    task automatic send(input logic [39:0] a, input int nsend, input int w,
                        input int wr_at, input int wa, input int wd,
                        input int exp_code, input string req);
        int pulses = 0;
        int ntot = (nsend > w + 1) ? nsend : w + 1;
        for (int i = 0; i <= ntot; i++) begin
            @(negedge clk);
            if (match_valid) pulses++;
            if (i == w + 1) begin
                chk({req, " valid"}, int'(match_valid), 1);
                chk({req, " hit"}, int'(match_hit), (exp_code != 7) ? 1 : 0);
                chk({req, " pipe"}, int'(match_pipe), exp_code);
            end
            if (i < nsend) begin
                rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = a[i*8 +: 8];
            end else begin
                rx_valid = 1'b0; rx_sof = 1'b0;
            end
            if (i == wr_at) begin
                cfg_we = 1'b1; cfg_addr = 4'(wa); cfg_wdata = 8'(wd);
            end else begin
                cfg_we = 1'b0;
            end
        end
        @(negedge clk);
        if (match_valid) pulses++;
        chk({req, " single result R8"}, pulses, 1);
        chk({req, " hold R8"}, int'(match_pipe), exp_code);
    endtask

    task automatic load_shared(input logic [31:0] sh, input logic [7:0] l1, input logic [7:0] l2,
                               input logic [7:0] l3, input logic [7:0] l4, input logic [7:0] l5);
        logic [7:0] lows [5];
        lows[0] = l1; lows[1] = l2; lows[2] = l3; lows[3] = l4; lows[4] = l5;
        for (int b = 0; b < 4; b++) wr(7 + b, sh[b*8 +: 8]);
        for (int p = 0; p < 5; p++) begin
            wr(11 + p, lows[p]);
            m_pa[p+1] = {sh, lows[p]};
        end
    endtask

    task automatic load_p0(input logic [39:0] a);
        for (int b = 0; b < 5; b++) wr(2 + b, a[b*8 +: 8]);
        m_pa[0] = a;
    endtask

    initial begin
        logic [39:0] tgt [8];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", int'(match_valid), 0);
        chk("R1 hit", int'(match_hit), 0);
        chk("R1 pipe", int'(match_pipe), 7);

        // R2 independent pipe 0 address, LSB first
        m_en = 6'b000001; wr(0, 1);
        m_w = 5; wr(1, 5);
        load_p0(40'h0F1E2D3C4B);
        load_shared(32'hA1B2C3D4, 8'h11, 8'h22, 8'h33, 8'h22, 8'h55);
        send(40'h0F1E2D3C4B, 5, 5, -1, 0, 0, 0, "R2 pipe0 match");
        send(40'h4B3C2D1E0F, 5, 5, -1, 0, 0, 7, "R2 byte order R6");

        // R9 restart on a new start byte
        @(negedge clk); rx_valid = 1; rx_sof = 1; rx_byte = 8'hAA;
        @(negedge clk); rx_sof = 0; rx_byte = 8'hBB;
        send(40'h0F1E2D3C4B, 5, 5, -1, 0, 0, 0, "R9 restart");

        // R4 illegal width writes ignored
        m_w = 3; wr(1, 3);
        wr(1, 2); wr(1, 6); wr(1, 0);
        send(40'hFFFF2D3C4B, 3, 3, -1, 0, 0, 0, "R4 width kept at 3");
        send(40'hFFFF2D3C4B, 5, 3, -1, 0, 0, 0, "R4 tail bytes ignored");

        // R10 write coincident with final byte applies; one later does not
        m_w = 5; wr(1, 5);
        wr(0, 0);
        send(40'h0F1E2D3C4B, 5, 5, 4, 0, 1, 0, "R10 same-edge write applies");
        send(40'h0F1E2D3C4B, 5, 5, 5, 0, 0, 0, "R10 late write not applied");

        // sweep: widths x all enable masks x aliasing targets (R3 R5 R6 R7)
        load_p0({32'hA1B2C3D4, 8'h33});   // aliases pipe 3
        tgt[0] = m_pa[0];
        tgt[1] = m_pa[1];
        tgt[2] = m_pa[2];                 // aliases pipe 4
        tgt[3] = m_pa[3];
        tgt[4] = m_pa[4];
        tgt[5] = m_pa[5];
        tgt[6] = m_pa[1] ^ 40'h5A00000000;
        tgt[7] = 40'h0102030405;
        for (int w = 3; w <= 5; w++) begin
            m_w = w; wr(1, w);
            for (int en = 0; en < 64; en++) begin
                m_en = 6'(en); wr(0, en);
                for (int t = 0; t < 8; t++) begin
                    send(tgt[t], (t % 2 == 1) ? 5 : w, w, -1, 0, 0, model(tgt[t]),
                         "R3 R5 R6 R7 sweep");
                end
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule